// File: doc/BRIEF.md
# M-out-of-N Code Checker

This block judges whether an N-bit word is a valid constant-weight codeword, meaning exactly M of its N rails are high. It is placed at the receiving end of a delay-insensitive link or behind a self-checking function unit. There it watches each word and reports two flags: a completion flag and an error flag. Both N (2 to 16) and M (1 to N) are parameters, so the same block covers the one-hot case (M = 1) and the balanced case (M = N/2).

The block does not count the ones in the word with an adder. It sorts the rails through a network of two-input compare-exchange cells, in which the high output is the OR of the two inputs and the low output is their AND. The network is an odd-even transposition arrangement with N stages, generated from the parameters. After sorting, every high rail has moved to the top of the vector. Completion is read from sorted position M-1 (the M-th rail from the top). Error is read from sorted position M. A parameter chooses whether the two flags leave the block straight from the logic or through a register with a synchronous reset.

The flag pair (completion, error) = (1, 0) marks a valid word. The pair (0, 0) marks an incomplete word or the all-zero spacer. The pair (1, 1) marks a word that has too many ones. The fault-free network never produces the pair (0, 1).

Top module: `mofn_checker`

## Requirements
- R1: A word with exactly M ones gives completion = 1 and error = 0.
- R2: A word with fewer than M ones, including the all-zero spacer, gives completion = 0 and error = 0.
- R3: A word with more than M ones gives completion = 1 and error = 1.
- R4: The flag pair completion = 0 with error = 1 is never produced.
- R5: With REG_OUT = 1, the flags on a clock edge reflect the word present at that edge and appear one cycle after the word is applied.
- R6: With REG_OUT = 1, a synchronous active-high reset forces both flags to 0 at the next edge, whatever the input word.
- R7: With REG_OUT = 0, the flags follow the input word in the same cycle, with no clock edge between them.
- R8: With M = 1, completion is high when any rail is high, and error is high when two or more rails are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional flag register |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| code_in | input | N | Word under test, one bit per rail |
| done_o | output | 1 | Completion flag: at least M rails are high |
| err_o | output | 1 | Error flag: more than M rails are high |

## Verification
The bound checker tests every cycle that the flags match the input's weight against the M threshold: exact weight, low weight and excess weight. It also tests that error never appears without completion, and that reset clears the registered flags. The bench shows what a per-cycle property cannot. It sweeps all 64 words of a 3-of-6 instance through a queue-based scoreboard alongside a 2-of-4 and a one-hot 1-of-5 instance. It shows the one-cycle hold-then-capture timing of the registered flags. It also shows that a reset applied while an over-weight word is present suppresses the error, and that the error returns once reset is released.

// File: rtl/mofn_pkg.sv
package mofn_pkg;

    // Flag pair carried through the datapath
    typedef struct packed {
        logic done;  // at least M rails high
        logic err;   // more than M rails high
    } chk_flags_t;

    localparam chk_flags_t FLAGS_IDLE = '{done: 1'b0, err: 1'b0};

    // Odd-even transposition: in stage s a cell starts at lane i when
    // i has the same parity as s and a lower neighbour lane exists.
    function automatic bit cell_leads(int stage, int lane, int width);
        return ((lane % 2) == (stage % 2)) && (lane + 1 < width);
    endfunction

    // Lane i is the low output of a cell started at lane i-1.
    function automatic bit cell_tails(int stage, int lane, int width);
        return (lane > 0) && cell_leads(stage, lane - 1, width);
    endfunction

endpackage

// File: rtl/mofn_cx_cell.sv
module mofn_cx_cell (
    input  logic a,
    input  logic b,
    output logic hi,
    output logic lo
);
    // Binary compare-exchange: maximum is OR, minimum is AND
    assign hi = a | b;
    assign lo = a & b;
endmodule

// File: rtl/mofn_sort_net.sv
module mofn_sort_net #(
    parameter int W = 6
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout   // ones gathered at low indices (top)
);
    import mofn_pkg::*;

    localparam int STAGES = W;

    logic [W-1:0] lvl [STAGES+1];

    assign lvl[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < W; i++) begin : g_lane
            if (cell_leads(s, i, W)) begin : g_cell
                mofn_cx_cell u_cx (
                    .a  (lvl[s][i]),
                    .b  (lvl[s][i+1]),
                    .hi (lvl[s+1][i]),
                    .lo (lvl[s+1][i+1])
                );
            end else if (!cell_tails(s, i, W)) begin : g_pass
                assign lvl[s+1][i] = lvl[s][i];
            end
        end
    end

    assign dout = lvl[STAGES];
endmodule

// File: rtl/mofn_taps.sv
module mofn_taps #(
    parameter int N = 6,
    parameter int M = 3
) (
    input  logic [N-1:0]          sorted,
    output mofn_pkg::chk_flags_t  flags
);
    localparam int DONE_TAP = M - 1;
    localparam int ERR_TAP  = M;

    logic unused_rails;
    assign unused_rails = ^sorted;

    assign flags.done = sorted[DONE_TAP];

    if (M < N) begin : g_err_tap
        assign flags.err = sorted[ERR_TAP];
    end else begin : g_err_none
        // every rail high is the only word of weight N: no excess possible
        assign flags.err = 1'b0;
    end
endmodule

// File: rtl/mofn_flag_stage.sv
module mofn_flag_stage #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mofn_pkg::chk_flags_t  d,
    output mofn_pkg::chk_flags_t  q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= mofn_pkg::FLAGS_IDLE;
            else     q <= d;
        end
    end else begin : g_comb
        logic unused_clocking;
        assign unused_clocking = clk ^ rst;
        assign q = d;
    end
endmodule

// File: rtl/mofn_checker.sv
module mofn_checker #(
    parameter int N       = 6,
    parameter int M       = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] code_in,
    output logic         done_o,
    output logic         err_o
);
    import mofn_pkg::*;

    if (N < 2 || N > 16 || M < 1 || M > N) begin : g_bad_params
        $error("mofn_checker: parameters out of range");
    end

    logic [N-1:0] sorted;
    chk_flags_t   raw_flags;
    chk_flags_t   out_flags;

    mofn_sort_net #(.W(N)) u_sort (
        .din  (code_in),
        .dout (sorted)
    );

    mofn_taps #(.N(N), .M(M)) u_taps (
        .sorted (sorted),
        .flags  (raw_flags)
    );

    mofn_flag_stage #(.REG_OUT(REG_OUT)) u_flags (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (out_flags)
    );

    assign done_o = out_flags.done;
    assign err_o  = out_flags.err;
endmodule

// File: rtl/mofn_checker_sva.sv
module mofn_checker_sva #(
    parameter int N       = 6,
    parameter int M       = 3,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] code_in,
    input logic         done_o,
    input logic         err_o
);
    AST_NO_LONE_ERROR: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o); // R4

    if (REG_OUT) begin : g_seq
        AST_EXACT_WEIGHT: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $countones($past(code_in)) == M) |-> (done_o && !err_o)); // R1
        AST_LOW_WEIGHT: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $countones($past(code_in)) < M) |-> (!done_o && !err_o)); // R2
        AST_OVER_WEIGHT: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $countones($past(code_in)) > M) |-> (done_o && err_o)); // R3
        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> (!done_o && !err_o)); // R6
    end else begin : g_comb
        AST_SAME_CYCLE_DONE: assert property (@(posedge clk) disable iff (rst)
            done_o == ($countones(code_in) >= M)); // R7
        AST_SAME_CYCLE_ERR: assert property (@(posedge clk) disable iff (rst)
            err_o == ($countones(code_in) > M)); // R7
    end
endmodule

bind mofn_checker mofn_checker_sva #(.N(N), .M(M), .REG_OUT(REG_OUT)) i_mofn_sva (
    .clk     (clk),
    .rst     (rst),
    .code_in (code_in),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/test_mofn_checker.sv
`timescale 1ns/1ps
module test_mofn_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] w6  = '0;
    logic [3:0] w4  = '0;
    logic [4:0] w5  = '0;
    logic       d6, e6, d4, e4, d5, e5;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [1:0] flags;
        string      req;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    // Registered 3-of-6 checker under scoreboard
    mofn_checker #(.N(6), .M(3), .REG_OUT(1'b1)) i_mofn_checker (
        .clk(clk), .rst(rst), .code_in(w6), .done_o(d6), .err_o(e6));

    // Combinational balanced 2-of-4 checker
    mofn_checker #(.N(4), .M(2), .REG_OUT(1'b0)) i_mofn_checker_b4 (
        .clk(clk), .rst(rst), .code_in(w4), .done_o(d4), .err_o(e4));

    // Combinational one-hot 1-of-5 checker
    mofn_checker #(.N(5), .M(1), .REG_OUT(1'b0)) i_mofn_checker_h5 (
        .clk(clk), .rst(rst), .code_in(w5), .done_o(d5), .err_o(e5));

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Expected flag pair from weight and threshold (R1/R2/R3)
    function automatic logic [1:0] ref_flags(int ones, int m);
        return {ones >= m, ones > m};
    endfunction

    function automatic string weight_tag(int ones, int m);
        if (ones == m) return "R1";
        if (ones < m)  return "R2";
        return "R3";
    endfunction

    task automatic drive6(logic [5:0] w, string extra);
        exp_t x;
        @(negedge clk);
        w6 = w;
        x.flags = ref_flags($countones(w), 3);
        x.req   = {weight_tag($countones(w), 3), extra};
        q.push_back(x);
    endtask

    // Monitor: the word pushed at a falling edge is captured at the next rising edge
    always @(posedge clk) begin
        exp_t x;
        #1;
        if (q.size() > 0) begin
            x = q.pop_front();
            check(x.req, {d6, e6}, x.flags);
            check("R4 lone error", {1'b0, (!d6 && e6)}, 2'b00);
        end
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        w6 = '1; w4 = '1; w5 = '1;
        repeat (3) @(negedge clk);
        #1 check("R6 reset with all rails high", {d6, e6}, 2'b00);

        @(negedge clk);
        rst = 1'b0;
        w6  = '0;

        // Exhaustive sweep: registered 3-of-6, same-cycle 2-of-4 and 1-of-5
        for (int v = 0; v < 64; v++) begin
            drive6(v[5:0], " sweep");
            w4 = v[3:0];
            w5 = v[4:0];
            #1;
            check({"R7 ", weight_tag($countones(w4), 2)}, {d4, e4},
                  ref_flags($countones(w4), 2));
            check("R8 one-hot", {d5, e5}, {|w5, $countones(w5) >= 2});
        end

        // Back-to-back alternation of full and spacer words
        for (int k = 0; k < 8; k++) begin
            drive6(k[0] ? 6'b000000 : 6'b111111, " R5 alternate");
        end
        for (int k = 0; k < 6; k++) begin
            drive6(6'b000111 << k[2:0], " R5 walking");
        end
        drive6(6'b000000, " R5 spacer");
        repeat (2) @(negedge clk);

        // Latency: new valid word not visible until the next rising edge
        @(negedge clk);
        w6 = 6'b101010;
        #1 check("R5 hold before edge", {d6, e6}, 2'b00);
        @(posedge clk);
        #1 check("R5 capture after edge", {d6, e6}, 2'b10);

        // Reset with an over-weight word present
        @(negedge clk);
        w6  = 6'b110110;
        rst = 1'b1;
        @(posedge clk);
        #1 check("R6 reset masks excess", {d6, e6}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1 check("R3 excess after reset release", {d6, e6}, 2'b11);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule